// File: doc/BRIEF.md
# Multi-Channel Grayscale PWM Sink Controller

This block drives sixteen current-sink enable lines, one per lamp channel. Each channel owns a 10-bit grayscale level, captured from a parallel bus into a per-channel holding register. A shared 10-bit period counter advances on falling edges of a grayscale clock. The source of that clock is chosen from two inputs by a select pin. The clock inputs and the blanking input are asynchronous to the system clock, so they are synchronised before their edges are detected.

A dimming period is armed when blanking is released (a high-to-low transition). It starts on the first grayscale clock falling edge that follows a rising edge after the release. At that edge every channel with a non-zero level becomes active. Each channel goes inactive once the shared count equals its level, so the on-time is exactly the level in grayscale clock periods. After the count reaches its top value, the period ends and every channel stays inactive until blanking is pulsed again. A polarity input chooses whether an active channel drives its pin high or low.

Top module: `gray_pwm_sink`

## Requirements
- R1: During and right after reset, with `pol_i` high, every bit of `sink_o` is 0, and the level registers hold zero.
- R2: Once blanking is released, the period begins on the first grayscale clock falling edge that follows a rising edge. A falling edge seen before any rising edge starts nothing.
- R3: A channel whose level L is non-zero is active for exactly L grayscale clock periods in each dimming period, as one unbroken pulse. Level 1023 gives 1023 periods.
- R4: A channel whose level is 0 is never active.
- R5: While blanking is high, every channel is inactive and the count is cleared. Grayscale clock edges are ignored until blanking falls again.
- R6: After the count reaches 1023, every channel stays inactive, whatever the grayscale clock does, until blanking has been high and then low again.
- R7: With `pol_i` = 1 an active channel drives its `sink_o` bit to 1. With `pol_i` = 0 it drives 0, and an inactive channel drives 1.
- R8: `gclk_sel_i` = 0 takes the grayscale clock from `gclk_a_i`, and `gclk_sel_i` = 1 takes it from `gclk_b_i`. The unselected input has no effect on `sink_o`.
- R9: Channel k's level is bits [10k+9:10k] of `data_i`. It is captured on each rising clock edge where `load_i` is 1. Changes on `data_i` while `load_i` is 0 do not affect `sink_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| blank_i | input | 1 | Blanking; high forces all channels off, its falling edge arms a period |
| gclk_a_i | input | 1 | Grayscale clock source A |
| gclk_b_i | input | 1 | Grayscale clock source B |
| gclk_sel_i | input | 1 | Grayscale clock source select (0 = A, 1 = B) |
| pol_i | input | 1 | Output polarity (1 = active high) |
| load_i | input | 1 | Capture strobe for the level registers |
| data_i | input | 160 | Packed channel levels, 10 bits per channel, channel 0 in the low bits |
| sink_o | output | 16 | Per-channel sink enables |

## Verification
A table of level sets is applied. Each set is built from a base value and a per-channel step, and each uses a different polarity and clock source. Together they cover a ramp that starts at zero, a set that mixes full scale with spread values, a mid-range set and a set crowded near the top. The ramp tells a zero channel apart from level 1. The near-top set tells an exact off-compare from one that ends early or late, and the full-scale channel shows whether the final count ends the period. Directed sequences then move the clock by hand around the blanking release, to separate a falling edge that comes before any rising edge from one that comes after. They also toggle only the unselected clock source, and raise blanking part way through a period.

// File: rtl/gpwm_pkg.sv
package gpwm_pkg;

   // Phases of one dimming period
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,   // blanked or waiting for release
      PH_ARM   = 3'd1,   // released, waiting for a grayscale rising edge
      PH_WAITF = 3'd2,   // rising edge seen, waiting for the starting fall
      PH_RUN   = 3'd3,   // counting falls, channels may be active
      PH_DONE  = 3'd4    // count exhausted, all channels dark
   } phase_t;

endpackage

// File: rtl/gpwm_edge_sync.sv
module gpwm_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic lvl_o,
   output logic rise_o,
   output logic fall_o
);

   logic sampled;
   logic prev_q;

   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
         $error("gpwm_edge_sync: STAGES must be 0..4");
      end

      if (STAGES == 0) begin : g_direct
         assign sampled = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else begin
               chain_q[0] <= d_i;
               for (int k = 1; k < STAGES; k++) begin
                  chain_q[k] <= chain_q[k-1];
               end
            end
         end
         assign sampled = chain_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sampled;
   end

   assign lvl_o  = sampled;
   assign rise_o = sampled & ~prev_q;
   assign fall_o = ~sampled & prev_q;

endmodule

// File: rtl/gpwm_sequencer.sv
module gpwm_sequencer
   import gpwm_pkg::*;
#(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         blank_lvl_i,
   input  logic         blank_fall_i,
   input  logic         gs_rise_i,
   input  logic         gs_fall_i,
   output logic         run_o,
   output logic [W-1:0] cnt_o
);

   localparam logic [W-1:0] LAST_STEP = {{(W-1){1'b1}}, 1'b0};

   phase_t       phase_q;
   logic [W-1:0] cnt_q;

   generate
      if (W < 2) begin : g_bad_width
         $error("gpwm_sequencer: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else if (blank_lvl_i) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (phase_q)
            PH_IDLE:  if (blank_fall_i) phase_q <= PH_ARM;
            PH_ARM:   if (gs_rise_i)    phase_q <= PH_WAITF;
            PH_WAITF: if (gs_fall_i) begin
                         phase_q <= PH_RUN;
                         cnt_q   <= '0;
                      end
            PH_RUN:   if (gs_fall_i) begin
                         cnt_q <= cnt_q + 1'b1;
                         if (cnt_q == LAST_STEP) phase_q <= PH_DONE;
                      end
            PH_DONE:  phase_q <= PH_DONE;
            default:  phase_q <= PH_IDLE;
         endcase
      end
   end

   assign run_o = (phase_q == PH_RUN);
   assign cnt_o = cnt_q;

   // R5
   blank_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blank_lvl_i |=> (cnt_q == '0 && !run_o));

   // R6
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_DONE && !blank_lvl_i) |=> (phase_q == PH_DONE));

   // R3
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_o && gs_fall_i && !blank_lvl_i) |=> (cnt_q == $past(cnt_q) + 1'b1));

   // R3
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_o && !gs_fall_i && !blank_lvl_i) |=> $stable(cnt_q));

   // R2
   start_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_o) |-> $past(gs_fall_i));

endmodule

// File: rtl/gpwm_channel.sv
module gpwm_channel #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] level_i,
   input  logic         run_i,
   input  logic [W-1:0] cnt_i,
   output logic         en_o
);

   logic [W-1:0] level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      level_q <= '0;
      else if (load_i) level_q <= level_i;
   end

   // active from the starting fall until the count meets the level
   assign en_o = run_i && (cnt_i < level_q);

   // R9
   level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(level_q));

   // R9
   level_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (level_q == $past(level_i)));

endmodule

// File: rtl/gray_pwm_sink.sv
module gray_pwm_sink #(
   parameter int CH          = 16,
   parameter int W           = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            blank_i,
   input  logic            gclk_a_i,
   input  logic            gclk_b_i,
   input  logic            gclk_sel_i,
   input  logic            pol_i,
   input  logic            load_i,
   input  logic [CH*W-1:0] data_i,
   output logic [CH-1:0]   sink_o
);

   localparam int DW = CH * W;

   logic          gs_raw;
   logic          gs_lvl, gs_rise, gs_fall;
   logic          blank_lvl, blank_rise, blank_fall;
   logic          run;
   logic [W-1:0]  cnt;
   logic [CH-1:0] en;
   logic [DW-1:0] data_w;

   generate
      if (CH < 1 || CH > 64) begin : g_bad_ch
         $error("gray_pwm_sink: CH must be 1..64");
      end
   endgenerate

   assign data_w = data_i;
   assign gs_raw = gclk_sel_i ? gclk_b_i : gclk_a_i;

   gpwm_edge_sync #(.STAGES(SYNC_STAGES)) u_gs_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    (gs_raw),
      .lvl_o  (gs_lvl),
      .rise_o (gs_rise),
      .fall_o (gs_fall)
   );

   gpwm_edge_sync #(.STAGES(SYNC_STAGES)) u_blank_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    (blank_i),
      .lvl_o  (blank_lvl),
      .rise_o (blank_rise),
      .fall_o (blank_fall)
   );

   gpwm_sequencer #(.W(W)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .blank_lvl_i  (blank_lvl),
      .blank_fall_i (blank_fall),
      .gs_rise_i    (gs_rise),
      .gs_fall_i    (gs_fall),
      .run_o        (run),
      .cnt_o        (cnt)
   );

   generate
      for (genvar k = 0; k < CH; k++) begin : g_chan
         gpwm_channel #(.W(W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (load_i),
            .level_i (data_w[k*W +: W]),
            .run_i   (run),
            .cnt_i   (cnt),
            .en_o    (en[k])
         );
      end
   endgenerate

   assign sink_o = pol_i ? en : ~en;

   // R7
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (sink_o == {CH{~pol_i}}));

   // R5
   blank_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_rise || blank_lvl) |=> (en == '0));

   // R3
   off_only_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !gs_lvl && !$past(gs_fall) && !load_i && !$past(load_i))
         |-> (($past(en) & ~en) == '0));

endmodule

// File: tb/gray_pwm_sink_test.sv
module gray_pwm_sink_test;

   localparam int CH   = 16;
   localparam int W    = 10;
   localparam int TOP  = 1 << W;
   localparam int HALF = 2;
   localparam int PER  = 2 * HALF;

   // base, step, polarity, clock select
   localparam int VEC [4][4] = '{
      '{0,    1,  1, 0},
      '{1023, 64, 0, 1},
      '{512,  33, 1, 1},
      '{1000, 1,  0, 0}
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            blank_i = 1'b1;
   logic            gclk_a_i = 1'b0;
   logic            gclk_b_i = 1'b0;
   logic            gclk_sel_i = 1'b0;
   logic            pol_i = 1'b1;
   logic            load_i = 1'b0;
   logic [CH*W-1:0] data_i = '0;
   logic [CH-1:0]   sink_o;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   int  vals   [CH];
   int  width  [CH];
   int  pulses [CH];
   bit  prev_act [CH];
   bit  mon_en = 1'b0;

   always #5 clk = ~clk;

   gray_pwm_sink uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .blank_i    (blank_i),
      .gclk_a_i   (gclk_a_i),
      .gclk_b_i   (gclk_b_i),
      .gclk_sel_i (gclk_sel_i),
      .pol_i      (pol_i),
      .load_i     (load_i),
      .data_i     (data_i),
      .sink_o     (sink_o)
   );

   always @(negedge clk) begin
      if (mon_en) begin
         for (int i = 0; i < CH; i++) begin
            bit act;
            act = pol_i ? sink_o[i] : ~sink_o[i];
            if (act) width[i]++;
            if (act && !prev_act[i]) pulses[i]++;
            prev_act[i] = act;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic set_gs(input bit v);
      if (gclk_sel_i) gclk_b_i = v;
      else            gclk_a_i = v;
   endtask

   task automatic gs_periods(input int n);
      for (int p = 0; p < n; p++) begin
         set_gs(1'b1); step(HALF);
         set_gs(1'b0); step(HALF);
      end
   endtask

   task automatic load_levels(input int base, input int stp);
      for (int i = 0; i < CH; i++) begin
         vals[i] = (base + i * stp) % TOP;
         data_i[i*W +: W] = vals[i][W-1:0];
      end
      load_i = 1'b1; step(1);
      load_i = 1'b0;
      data_i = ~data_i;   // must be ignored without a load (R9)
      step(1);
   endtask

   task automatic clear_mon();
      for (int i = 0; i < CH; i++) begin
         width[i] = 0; pulses[i] = 0; prev_act[i] = 1'b0;
      end
   endtask

   task automatic run_vec(input int base, input int stp, input bit pol, input bit sel);
      blank_i = 1'b1; gclk_a_i = 1'b0; gclk_b_i = 1'b0;
      pol_i = pol; gclk_sel_i = sel;
      step(6);
      load_levels(base, stp);
      clear_mon();
      mon_en = 1'b1;
      blank_i = 1'b0; step(8);
      gs_periods(TOP + 20);
      step(4);
      mon_en = 1'b0;
      for (int i = 0; i < CH; i++) begin
         // R3 / R4 / R9: width equals the loaded level in grayscale periods
         chk(width[i] == vals[i] * PER, vals[i] == 0 ? "R4 zero level width" : "R3 width",
             width[i], vals[i] * PER);
         chk(pulses[i] == (vals[i] != 0 ? 1 : 0), "R3 R6 single pulse", pulses[i],
             vals[i] != 0 ? 1 : 0);
      end
      // R6 + R7: after the count tops out all pins sit at the inactive level
      chk(sink_o == {CH{~pol}}, "R6 R7 idle after period", sink_o, {CH{~pol}});
      blank_i = 1'b1; step(6);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      step(3);
      chk(sink_o == '0, "R1 reset output", sink_o, 0);
      rst_n = 1'b1; step(4);
      chk(sink_o == '0, "R1 after reset output", sink_o, 0);
      // R1: level registers are zero, so a period lights nothing
      clear_mon(); mon_en = 1'b1;
      blank_i = 1'b0; step(8);
      gs_periods(6);
      mon_en = 1'b0;
      chk(pulses[0] == 0 && sink_o == '0, "R1 zero levels after reset", pulses[0], 0);
      blank_i = 1'b1; step(6);

      // table of level sets
      for (int v = 0; v < 4; v++) begin
         run_vec(VEC[v][0], VEC[v][1], VEC[v][2] != 0, VEC[v][3] != 0);
      end

      // R2: fall before any rise does not start
      pol_i = 1'b1; gclk_sel_i = 1'b0; gclk_a_i = 1'b1;
      load_levels(5, 0);
      step(4);
      blank_i = 1'b0; step(8);
      gclk_a_i = 1'b0; step(8);
      chk(sink_o == '0, "R2 early fall ignored", sink_o, 0);
      gclk_a_i = 1'b1; step(8);
      chk(sink_o == '0, "R2 rise alone no start", sink_o, 0);
      gclk_a_i = 1'b0; step(8);
      chk(sink_o == {CH{1'b1}}, "R2 start on fall after rise", sink_o, {CH{1'b1}});

      // R5: blanking mid-period forces all off and ignores the clock
      blank_i = 1'b1; step(8);
      chk(sink_o == '0, "R5 blank forces off", sink_o, 0);
      gs_periods(10);
      chk(sink_o == '0, "R5 clock ignored while blanked", sink_o, 0);

      // R7: inverted polarity while blanked
      pol_i = 1'b0; step(1);
      chk(sink_o == {CH{1'b1}}, "R7 inverted idle level", sink_o, {CH{1'b1}});
      pol_i = 1'b1; step(1);

      // R8: unselected source has no effect
      gclk_sel_i = 1'b1; gclk_a_i = 1'b0; gclk_b_i = 1'b0; step(4);
      blank_i = 1'b0; step(8);
      for (int p = 0; p < 10; p++) begin
         gclk_a_i = 1'b1; step(HALF);
         gclk_a_i = 1'b0; step(HALF);
      end
      step(4);
      chk(sink_o == '0, "R8 unselected clock ignored", sink_o, 0);
      gs_periods(1);
      step(4);
      chk(sink_o == {CH{1'b1}}, "R8 selected clock starts", sink_o, {CH{1'b1}});
      blank_i = 1'b1; step(8);

      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule